// File: doc/BRIEF.md
# A16 Logical Address Decoder

This block recognises short-address (16-bit) accesses on an asynchronous instrument backplane for a register-based slave card. The local address range is reached with one of two address-modifier codes. The top two address bits must point at the configuration space. The next eight bits must equal the card's logical address, which is set by configuration switches. When all of these hold, the block pulls an active-low card-select low and forwards the five lowest address bits as a register index.

The address strobe arrives without any relation to the local clock. It passes through a two-flop synchroniser. On the synchronised falling edge, the block captures the decode result and the register index. Both stay frozen for as long as the strobe is held low. When the strobe rises, card-select returns high. The strobe is not a stream: there is no back-pressure, and a new access begins only after the strobe goes high again.

Top module: `a16_la_decoder`

## Requirements
- R1: After reset, `csel_n_o` is 1 and `reg_idx_o` is 0.
- R2: A select needs `amod_i` equal to 6'h29 or 6'h2D at capture. Any other of the 64 codes leaves `csel_n_o` at 1.
- R3: A select needs `addr_i[15]` and `addr_i[14]` both equal to 1 at capture.
- R4: A select needs `addr_i[13:6]` equal to `la_sw_i[7:0]` bit for bit at capture.
- R5: With the strobe low and R2 to R4 met, `csel_n_o` goes low on the third rising clock edge after the strobe falls, and not before.
- R6: On that same edge, `reg_idx_o` takes `addr_i[5:1]` (bit 1 maps to index bit 0). This happens for every access, whether or not the card is selected.
- R7: While the strobe stays low, changes on `addr_i`, `amod_i` and `la_sw_i` have no effect on `csel_n_o` or `reg_idx_o`.
- R8: `csel_n_o` returns to 1 on the third rising edge after the strobe rises, and stays 1 while the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 15 | Backplane address bits 15 down to 1 |
| amod_i | input | 6 | Address modifier code |
| astrb_n_i | input | 1 | Asynchronous address strobe, active low |
| la_sw_i | input | 8 | Logical address from switches |
| csel_n_o | output | 1 | Card select, active low |
| reg_idx_o | output | 5 | Register index captured from addr_i[5:1] |

## Verification
A synchroniser stage that is stuck or missing moves the select edge off the third clock after either strobe edge. That shift shows at `csel_n_o` within one access. A wrong comparator bit or modifier code gives a wrong select on the first access that sweeps that value. A capture register that keeps following its inputs shows up as a change in `csel_n_o` or `reg_idx_o` within two clocks of disturbing the inputs while the strobe is held low.

// File: rtl/a16dec_pkg.sv
package a16dec_pkg;
  localparam int AM_W       = 6;
  localparam int PFX_W      = 2;
  localparam logic [AM_W-1:0] AM_CODE_A = 6'h29;
  localparam logic [AM_W-1:0] AM_CODE_B = 6'h2D;
  localparam int N_AM_CODES = 2;
endpackage

// File: rtl/a16dec_strb_sync.sv
module a16dec_strb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic lvl_n,
  output logic fell
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-1:0], async_n};
  end

  assign lvl_n = chain_q[STAGES-1];
  assign fell  = chain_q[STAGES] & ~chain_q[STAGES-1];

  // R5: a falling edge is reported for one cycle only
  a_r5_fell_single: assert property (@(posedge clk) disable iff (!rst_n)
    fell |=> !fell);
endmodule

// File: rtl/a16dec_match.sv
module a16dec_match import a16dec_pkg::*; #(
  parameter int LA_W  = 8,
  parameter int IDX_W = 5
) (
  input  logic [AM_W-1:0]             amod,
  input  logic [PFX_W+LA_W+IDX_W:1]   addr,
  input  logic [LA_W-1:0]             la_sw,
  output logic                        hit
);
  localparam int LA_LO = IDX_W + 1;
  localparam int LA_HI = IDX_W + LA_W;
  localparam int TOP   = PFX_W + LA_W + IDX_W;

  logic [N_AM_CODES-1:0] am_ok;
  logic [AM_W-1:0]       codes [N_AM_CODES];

  assign codes[0] = AM_CODE_A;
  assign codes[1] = AM_CODE_B;

  for (genvar g = 0; g < N_AM_CODES; g++) begin : g_am
    assign am_ok[g] = (amod == codes[g]);
  end

  logic pfx_ok, la_ok;
  assign pfx_ok = &addr[TOP:LA_HI+1];
  assign la_ok  = (addr[LA_HI:LA_LO] == la_sw);
  assign hit    = (|am_ok) & pfx_ok & la_ok;
endmodule

// File: rtl/a16dec_capture.sv
module a16dec_capture #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_n,
  input  logic             fell,
  input  logic             hit,
  input  logic [IDX_W-1:0] idx_in,
  output logic             csel_n,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csel_n <= 1'b1;
      idx    <= '0;
    end else if (idle_n) begin
      csel_n <= 1'b1;
    end else if (fell) begin
      csel_n <= ~hit;
      idx    <= idx_in;
    end
  end

  // R7: frozen while strobe held low
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_n && !fell) |=> ($stable(csel_n) && $stable(idx)));
  // R8: released when strobe inactive
  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    idle_n |=> csel_n);
endmodule

// File: rtl/a16_la_decoder.sv
module a16_la_decoder import a16dec_pkg::*; #(
  parameter int LA_W        = 8,
  parameter int IDX_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PFX_W+LA_W+IDX_W:1] addr_i,
  input  logic [AM_W-1:0]           amod_i,
  input  logic                      astrb_n_i,
  input  logic [LA_W-1:0]           la_sw_i,
  output logic                      csel_n_o,
  output logic [IDX_W-1:0]          reg_idx_o
);
  localparam int TOP   = PFX_W + LA_W + IDX_W;
  localparam int LA_LO = IDX_W + 1;

  logic strb_lvl_n, strb_fell, hit;

  a16dec_strb_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_n(astrb_n_i),
    .lvl_n(strb_lvl_n), .fell(strb_fell)
  );

  a16dec_match #(.LA_W(LA_W), .IDX_W(IDX_W)) match_i (
    .amod(amod_i), .addr(addr_i), .la_sw(la_sw_i), .hit(hit)
  );

  a16dec_capture #(.IDX_W(IDX_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .idle_n(strb_lvl_n), .fell(strb_fell),
    .hit(hit), .idx_in(addr_i[IDX_W:1]),
    .csel_n(csel_n_o), .idx(reg_idx_o)
  );

  // R5: select only appears right after a detected strobe fall
  a_r5_sel_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csel_n_o) |-> $past(strb_fell));
  // R2: modifier code was one of the two accepted values
  a_r2_am_code: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csel_n_o) |-> ($past(amod_i) == AM_CODE_A || $past(amod_i) == AM_CODE_B));
  // R3: configuration-space prefix was present
  a_r3_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csel_n_o) |-> (&$past(addr_i[TOP:TOP-PFX_W+1])));
  // R4: logical address field matched the switches
  a_r4_la_match: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csel_n_o) |-> ($past(addr_i[TOP-PFX_W:LA_LO]) == $past(la_sw_i)));
  // R6: index taken from the low address bits at capture
  a_r6_idx: assert property (@(posedge clk) disable iff (!rst_n)
    strb_fell |=> (reg_idx_o == $past(addr_i[IDX_W:1])));
endmodule

// File: tb/a16_la_decoder_tb.sv
module a16_la_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:1] addr_i = '0;
  logic [5:0]  amod_i = '0;
  logic        astrb_n_i = 1'b1;
  logic [7:0]  la_sw_i = '0;
  logic        csel_n_o;
  logic [4:0]  reg_idx_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  a16_la_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .amod_i(amod_i),
    .astrb_n_i(astrb_n_i), .la_sw_i(la_sw_i),
    .csel_n_o(csel_n_o), .reg_idx_o(reg_idx_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [5:0] am, input logic [15:1] a, input logic [7:0] la);
    logic exp_sel;
    exp_sel = (am == 6'h29 || am == 6'h2D) && a[15] && a[14] && (a[13:6] == la);
    @(negedge clk);
    amod_i = am; addr_i = a; la_sw_i = la; astrb_n_i = 1'b0;
    repeat (2) @(posedge clk);
    #1 chk("R5 early", {7'd0, csel_n_o}, 8'd1);
    @(posedge clk);
    #1 chk("R2/R3/R4/R5 select", {7'd0, csel_n_o}, {7'd0, ~exp_sel});
    chk("R6 index", {3'd0, reg_idx_o}, {3'd0, a[5:1]});
    @(negedge clk);
    addr_i = ~a; amod_i = exp_sel ? 6'h00 : 6'h29; la_sw_i = ~la;
    repeat (2) @(posedge clk);
    #1 chk("R7 hold sel", {7'd0, csel_n_o}, {7'd0, ~exp_sel});
    chk("R7 hold idx", {3'd0, reg_idx_o}, {3'd0, a[5:1]});
    @(negedge clk);
    astrb_n_i = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R8 release", {7'd0, csel_n_o}, 8'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1 csel reset", {7'd0, csel_n_o}, 8'd1);
    chk("R1 idx reset", {3'd0, reg_idx_o}, 8'd0);
    @(negedge clk) rst_n = 1'b1;
    // R2: every modifier code
    for (int m = 0; m < 64; m++) access(6'(m), {2'b11, 8'h5A, 5'h13}, 8'h5A);
    // R3: every prefix combination
    for (int p = 0; p < 4; p++) access(6'h2D, {2'(p), 8'hC3, 5'h07}, 8'hC3);
    // R4: every address byte against several switch settings
    for (int s = 0; s < 3; s++) begin
      logic [7:0] la;
      la = (s == 0) ? 8'h00 : (s == 1) ? 8'hA5 : 8'hFF;
      for (int b = 0; b < 256; b++) access(6'h29, {2'b11, 8'(b), 5'(b)}, la);
    end
    // R6: every index value
    for (int i = 0; i < 32; i++) access(6'h29, {2'b11, 8'h3C, 5'(i)}, 8'h3C);
    // R8: idle stays high
    repeat (5) @(posedge clk);
    #1 chk("R8 idle", {7'd0, csel_n_o}, 8'd1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule